// File: doc/BRIEF.md
# Small SRAM Functional Test Sequencer

This block is a self-running test controller for a 16-word by 4-bit static RAM. The RAM has separate data-in and data-out buses and active-low chip-select and write-enable strobes, and its outputs float when disabled. A one-cycle start pulse launches a fixed sequence of 29 steps. Each step is a write, a read, or a write attempt made with the chip deselected.

The sequence has three parts. The first writes a thermometer pattern to thermometer addresses and reads it back. The second checks that a write attempted with chip select inactive leaves memory untouched. The third toggles each data bit on its own at address zero. Each step is built from phases, and every phase lasts a parameter number of clock cycles. This leaves setup and hold margin around every strobe edge.

Read data is compared only inside the window where the RAM drives its outputs. The first mismatch is captured together with its step number, the expected value and the observed value. The sequence always runs to its last step and then reports the result with a one-cycle done pulse.

Top module: `sram_probe_seq`

## Requirements
- R1: After reset the block is idle: busy, done, pass and fail are 0, and both RAM strobes (ramCsN, ramWeN) are 1. The strobes also return to 1 whenever the block is idle after a run.
- R2: Each write step uses five phases with the strobes (csN,weN) = 11, 01, 00, 10, 11 and the address and data held for the whole step. Chip select never falls while write enable is low.
- R3: Steps 0..4 write data 1111>>k to address (1<<k)-1 for k = 0..4. Steps 5..9 read the same addresses in the same order and expect the same data on all four bits.
- R4: Read data is sampled only at the end of the second phase of a read step (csN=0, weN=1). A read step has three phases: 01, 01, 11.
- R5: Step 10 writes 0000 to address 0. Step 11 drives data 1111 with weN low while csN stays high, in the phases 11, 10, 11. Step 12 reads address 0 and expects 0000.
- R6: Steps 13+4b .. 16+4b test data bit b (b = 0..3) at address 0: write 0000, read, write 1<<b, read. Each of these reads compares only bit b, so faults on the other bits have no effect.
- R7: Every phase lasts STEP_CYCLES clock cycles (default 2). With the default, done rises 230 clock edges after the edge that accepted start.
- R8: The first mismatch sets fail and latches failStep, failExp and failObs. The latched failExp and failObs are masked to the compared bits. Later mismatches do not change them, and the run continues to the last step.
- R9: done is high for exactly one cycle at the end of a run. pass is high in that same cycle if and only if no mismatch occurred. A new start clears the fail record.
- R10: A start pulse while busy is ignored and does not change the timing of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | High with done when no mismatch occurred |
| fail | output | 1 | Sticky mismatch flag for the current run |
| failStep | output | 5 | Step index of the first mismatch |
| failExp | output | 4 | Expected value of the first mismatch (masked) |
| failObs | output | 4 | Observed value of the first mismatch (masked) |
| ramAddr | output | 4 | RAM address |
| ramDin | output | 4 | RAM write data |
| ramDout | input | 4 | RAM read data |
| ramCsN | output | 1 | RAM chip select, active low |
| ramWeN | output | 1 | RAM write enable, active low |

## Verification
Two events can fall in the same cycle:
- The last compare of a run and the final done pulse lie only a few cycles apart.
- The sample of a mismatching read can coincide with a fail already latched from an earlier step.

The bench provokes both with a behavioural RAM carrying injected faults. Stuck-at faults mismatch on many steps, so each later mismatch falls on an existing fail record; the bench judges that the record still names the first step. A fault that only bites on the final read, step 28, puts the capture right before done, and the bench judges that done shows the record already complete. A start pulse issued in the middle of a run checks that the done timing is unchanged.

// File: rtl/sramseq_pkg.sv
package sramseq_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 4;
  localparam int PAT_WORDS = DATA_W + 1;
  localparam int LOCK_BASE = 2 * PAT_WORDS;
  localparam int BIT_BASE  = LOCK_BASE + 3;
  localparam int NUM_STEPS = BIT_BASE + 4 * DATA_W;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic [1:0] {OP_WRITE, OP_READ, OP_LOCK} opKind_e;

  typedef struct packed {
    opKind_e             kind;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
    logic [DATA_W-1:0]   expv;
    logic [DATA_W-1:0]   mask;
  } stepOp_t;

  typedef struct packed {
    logic                clear;
    logic                sample;
    logic                finish;
    logic [STEP_W-1:0]   stepIdx;
    logic [DATA_W-1:0]   expv;
    logic [DATA_W-1:0]   mask;
  } ctlStrobe_t;

  // Decode a step index into its operation; computed, not tabulated.
  function automatic stepOp_t opAt(input logic [STEP_W-1:0] idx);
    stepOp_t o;
    int i, j, b;
    logic [DATA_W-1:0] ones;
    logic [DATA_W-1:0] bitv;
    ones   = '1;
    i      = int'(idx);
    o.kind = OP_WRITE;
    o.addr = '0;
    o.data = '0;
    o.expv = '0;
    o.mask = ones;
    if (i < PAT_WORDS) begin
      o.addr = ADDR_W'((1 << i) - 1);
      o.data = ones >> i;
    end else if (i < LOCK_BASE) begin
      j      = i - PAT_WORDS;
      o.kind = OP_READ;
      o.addr = ADDR_W'((1 << j) - 1);
      o.expv = ones >> j;
    end else if (i == LOCK_BASE) begin
      o.kind = OP_WRITE;
    end else if (i == LOCK_BASE + 1) begin
      o.kind = OP_LOCK;
      o.data = ones;
    end else if (i == LOCK_BASE + 2) begin
      o.kind = OP_READ;
    end else begin
      j    = i - BIT_BASE;
      b    = j / 4;
      bitv = DATA_W'(1) << b;
      case (j % 4)
        0: o.kind = OP_WRITE;
        1: begin o.kind = OP_READ; o.mask = bitv; end
        2: begin o.kind = OP_WRITE; o.data = bitv; end
        default: begin o.kind = OP_READ; o.mask = bitv; o.expv = bitv; end
      endcase
    end
    return o;
  endfunction
endpackage

// File: rtl/sramseq_ctrl.sv
module sramseq_ctrl
  import sramseq_pkg::*;
#(
  parameter int STEP_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramDin,
  output logic              ramCsN,
  output logic              ramWeN,
  output ctlStrobe_t        strobe
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

  logic [STEP_W-1:0] stepIdx;
  logic [2:0]        phase;
  logic [CW-1:0]     cycCnt;
  stepOp_t           op;
  logic [2:0]        nPhase;
  logic              lastCyc, lastPhase, lastStep;

  always_comb begin
    op        = opAt(stepIdx);
    nPhase    = (op.kind == OP_WRITE) ? 3'd5 : 3'd3;
    lastCyc   = (cycCnt == CW'(STEP_CYCLES - 1));
    lastPhase = (phase == nPhase - 3'd1);
    lastStep  = (stepIdx == STEP_W'(NUM_STEPS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepIdx <= '0;
      phase   <= '0;
      cycCnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        stepIdx <= '0;
        phase   <= '0;
        cycCnt  <= '0;
      end
    end else if (!lastCyc) begin
      cycCnt <= cycCnt + CW'(1);
    end else begin
      cycCnt <= '0;
      if (!lastPhase) begin
        phase <= phase + 3'd1;
      end else begin
        phase <= '0;
        if (lastStep) busy <= 1'b0;
        else          stepIdx <= stepIdx + STEP_W'(1);
      end
    end
  end

  // Strobe pattern per operation kind and phase.
  always_comb begin
    ramCsN  = 1'b1;
    ramWeN  = 1'b1;
    ramAddr = '0;
    ramDin  = '0;
    if (busy) begin
      ramAddr = op.addr;
      ramDin  = op.data;
      case (op.kind)
        OP_WRITE: begin
          ramCsN = !(phase == 3'd1 || phase == 3'd2);
          ramWeN = !(phase == 3'd2 || phase == 3'd3);
        end
        OP_READ:  ramCsN = (phase == 3'd2);
        default:  ramWeN = (phase != 3'd1);
      endcase
    end
  end

  always_comb begin
    strobe.clear   = start && !busy;
    strobe.sample  = busy && (op.kind == OP_READ) && (phase == 3'd1) && lastCyc;
    strobe.finish  = busy && lastCyc && lastPhase && lastStep;
    strobe.stepIdx = stepIdx;
    strobe.expv    = op.expv & op.mask;
    strobe.mask    = op.mask;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ramCsN && ramWeN));
  p_cs_fall_safe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramCsN) |-> ramWeN);
  p_write_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !ramWeN && !$past(ramWeN)) |-> ($stable(ramAddr) && $stable(ramDin)));
  p_sample_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |-> (!ramCsN && ramWeN));
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !(busy && stepIdx == '0 && phase == '0 && cycCnt == '0));
endmodule

// File: rtl/sramseq_dpath.sv
module sramseq_dpath
  import sramseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] ramDout,
  output logic              done,
  output logic              pass,
  output logic              failFlag,
  output logic [STEP_W-1:0] failStep,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs
);
  logic [DATA_W-1:0] obsMasked;
  logic              mismatch;

  always_comb begin
    obsMasked = ramDout & strobe.mask;
    mismatch  = (obsMasked != strobe.expv);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failFlag <= 1'b0;
      failStep <= '0;
      failExp  <= '0;
      failObs  <= '0;
      done     <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.clear) begin
        failFlag <= 1'b0;
        failStep <= '0;
        failExp  <= '0;
        failObs  <= '0;
      end else if (strobe.sample && mismatch && !failFlag) begin
        failFlag <= 1'b1;
        failStep <= strobe.stepIdx;
        failExp  <= strobe.expv;
        failObs  <= obsMasked;
      end
    end
  end

  assign pass = done && !failFlag;

  p_first_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && mismatch && !strobe.clear) |=> failFlag);
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !strobe.clear) |=> (failFlag && $stable(failStep) && $stable(failObs)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/sram_probe_seq.sv
module sram_probe_seq
  import sramseq_pkg::*;
#(
  parameter int STEP_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [STEP_W-1:0] failStep,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramDin,
  input  logic [DATA_W-1:0] ramDout,
  output logic              ramCsN,
  output logic              ramWeN
);
  ctlStrobe_t strobe;

  sramseq_ctrl #(.STEP_CYCLES(STEP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy),
    .ramAddr(ramAddr), .ramDin(ramDin), .ramCsN(ramCsN), .ramWeN(ramWeN),
    .strobe(strobe)
  );

  sramseq_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ramDout(ramDout),
    .done(done), .pass(pass), .failFlag(fail),
    .failStep(failStep), .failExp(failExp), .failObs(failObs)
  );
endmodule

// File: tb/sim_sram_probe_seq.sv
`timescale 1ns/1ps
module sim_sram_probe_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       busy, done, pass, fail, ramCsN, ramWeN;
  logic [4:0] failStep;
  logic [3:0] failExp, failObs, ramAddr, ramDin, ramDout;

  int errors = 0;
  int checks = 0;
  int mode = 0;
  int fb = 0;
  logic [3:0] mem [16];

  always #2.5 clk = ~clk;

  sram_probe_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .failStep(failStep), .failExp(failExp),
    .failObs(failObs), .ramAddr(ramAddr), .ramDin(ramDin), .ramDout(ramDout),
    .ramCsN(ramCsN), .ramWeN(ramWeN)
  );

  // Behavioural RAM with injectable faults:
  // 1 stuck-at-1 bit fb, 2 stuck-at-0 bit fb, 3 write ignores chip select,
  // 4 flips non-tested bits at addr 0 in the per-bit phase, 5 flips bit fb when addr 0 holds 1<<fb.
  always @(posedge clk) begin
    if (!ramWeN && (!ramCsN || mode == 3)) mem[ramAddr] <= ramDin;
  end

  always_comb begin
    logic [3:0] v;
    v = mem[ramAddr];
    case (mode)
      1: v = v | (4'd1 << fb);
      2: v = v & ~(4'd1 << fb);
      4: if (ramAddr == 4'd0 && (v == 4'd1 || v == 4'd8)) v = v ^ 4'b0110;
      5: if (ramAddr == 4'd0 && v == (4'd1 << fb)) v = v ^ (4'd1 << fb);
      default: ;
    endcase
    ramDout = (!ramCsN && ramWeN) ? v : 4'bzzzz;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected run length: 14 writes x5 phases, 14 reads x3, one lockout x3, 2 cycles each.
  localparam int EXP_EDGES = (14 * 5 + 14 * 3 + 3) * 2;

  task automatic runOne(input int m, input int b, input bit midStart, input bit expFail,
                        input int expStep, input int expExp, input int expObs);
    int cnt;
    mode = m; fb = b;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 0;
    while (!done && cnt < 1000) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (midStart) start = (cnt == 50);
    end
    start = 1'b0;
    chk($sformatf("R7 run length m%0d b%0d", m, b), cnt, EXP_EDGES);
    chk($sformatf("R9 pass m%0d b%0d", m, b), int'(pass), int'(!expFail));
    chk($sformatf("R8 fail m%0d b%0d", m, b), int'(fail), int'(expFail));
    if (expFail) begin
      chk($sformatf("R8 failStep m%0d b%0d", m, b), int'(failStep), expStep);
      chk($sformatf("R8 failExp m%0d b%0d", m, b), int'(failExp), expExp);
      chk($sformatf("R8 failObs m%0d b%0d", m, b), int'(failObs), expObs);
    end
    @(negedge clk);
    chk($sformatf("R9 done one cycle m%0d", m), int'(done), 0);
    chk($sformatf("R1 idle strobes m%0d", m), int'({busy, ramCsN, ramWeN}), 3);
  endtask

  initial begin
    for (int a = 0; a < 16; a++) mem[a] = 4'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy/done/fail", int'({busy, done, fail, pass}), 0);
    chk("R1 reset strobes", int'({ramCsN, ramWeN}), 3);
    rstN = 1'b1;
    @(negedge clk);
    // R3 R4 R5 R6: fault-free run passes; R10: mid-run start ignored.
    runOne(0, 0, 1'b0, 1'b0, 0, 0, 0);
    runOne(0, 0, 1'b1, 1'b0, 0, 0, 0);
    // R3 R8: stuck-at-1 first fails at pattern read k = 4-b.
    for (int b = 0; b < 4; b++)
      runOne(1, b, 1'b0, 1'b1, 5 + 4 - b, 15 >> (4 - b), (15 >> (4 - b)) | (1 << b));
    // R3 R8 R9: stuck-at-0 fails everywhere; first record is step 5; new start clears.
    for (int b = 0; b < 4; b++)
      runOne(2, b, 1'b0, 1'b1, 5, 15, 15 & ~(1 << b));
    // R5: write leaking with chip select high caught at step 12.
    runOne(3, 0, 1'b0, 1'b1, 12, 0, 15);
    // R6: untested bits corrupted, no effect.
    runOne(4, 0, 1'b0, 1'b0, 0, 0, 0);
    // R6 R8: tested bit flipped, caught on the last read of that bit.
    for (int b = 0; b < 4; b++)
      runOne(5, b, 1'b0, 1'b1, 16 + 4 * b, 1 << b, 0);
    runOne(0, 0, 1'b1, 1'b0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule